// File: doc/BRIEF.md
# Input Event Timestamp Queue

This block watches a bank of general-purpose input pins for level transitions and records when they happen. Up to eight event channels are available. Each channel picks its source from any of the twelve pins and can be set to react to rising edges, falling edges, both or neither. Every pin first passes through a two-stage synchronizer. A qualifying edge then causes the block to store a record in an eight-entry first-in first-out queue. The record holds the free-running time value, corrected for the fixed input latency, along with the channel number and the edge direction.

Software sees a ready flag whenever a record is waiting. The head record's channel, direction, missed-event count and timestamp are always visible on the outputs, and looking at them has no side effect. Taking the timestamp is signalled by a one-cycle read strobe, which removes the head record. When the queue is full, new edges are dropped and counted in a counter that saturates at 3. That count is attached to the next record that does get stored, so software learns how many events were lost just before it.

Top module: `evq_stamp_queue`

## Requirements
- R1: A transition on a selected pin, applied just before clock edge P1, is stored at edge P3. The ready flag is therefore still low after P2 and high after P3.
- R2: Each channel has a 2-bit mode: 0 = off, 1 = rising only, 2 = falling only, 3 = both. The stored direction bit is 1 for a rising edge and 0 for a falling edge.
- R3: Channel k takes its source pin from the 4-bit field `ch_sel_i[4k+3:4k]`. A value of 12 or more selects a constant low, so that channel never fires. Pins that no enabled channel selects never produce a record.
- R4: The stored timestamp equals `time_i` at the storing edge minus 35, taken modulo 2^32.
- R5: `ready_o` is high exactly when at least one record is held, and it only falls after a read strobe.
- R6: A read strobe while ready removes the head record. A read strobe while empty has no effect. Without a read strobe, the head outputs hold their value.
- R7: Channels that fire in the same cycle are stored in ascending channel number, all with the same timestamp.
- R8: The queue holds 8 records. An edge arriving when the queue is full is dropped, and the lost count is incremented, saturating at 3. The next stored record carries that count in `stat_miss_o`, and the count then restarts from 0. All other records carry 0.
- R9: When a read strobe and a new edge fall in the same cycle on a full queue, the read is applied first. The new edge is stored and is not counted as lost.
- R10: After reset the queue is empty and the lost count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| pin_i | input | 12 | Asynchronous general-purpose input pins |
| time_i | input | 32 | Current time value |
| ch_mode_i | input | 16 | 2-bit edge mode per channel, channel k at [2k+1:2k] |
| ch_sel_i | input | 32 | 4-bit pin select per channel, channel k at [4k+3:4k] |
| rd_ts_i | input | 1 | Read strobe that pops the head record |
| ready_o | output | 1 | At least one record is waiting |
| stat_ch_o | output | 3 | Channel number of the head record |
| stat_rise_o | output | 1 | Head record direction, 1 = rising |
| stat_miss_o | output | 2 | Events lost just before the head record |
| ts_o | output | 32 | Compensated timestamp of the head record |

## Verification
Capture and removal can land in the same cycle. The hard case is a full queue, where the order of the two decides whether the new edge is kept or counted as lost. The bench fills the queue, toggles a pin, and then times the read strobe so that the pop falls on exactly the edge where the transition is stored. It judges the result by draining the queue: it expects eight records, none carrying a lost count, with the last one holding the later timestamp. A separate run fills the queue and keeps overrunning it, then checks three things: that the saturated count appears only on the first record stored after space is freed, that the records ahead of it show no count, and that the count is gone from the next record.

// File: rtl/evq_pkg.sv
package evq_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    localparam int MISS_W = 2;

    function automatic logic [MISS_W-1:0] miss_inc(input logic [MISS_W-1:0] m);
        return (m == {MISS_W{1'b1}}) ? m : m + 1'b1;
    endfunction

endpackage

// File: rtl/evq_sync.sv
module evq_sync #(
    parameter int N      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [STAGES-1:0][N-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= '0;
        else          sync_q <= sync_d;
    end

    assign sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/evq_edge.sv
module evq_edge
    import evq_pkg::*;
#(
    parameter int NUM_PINS = 12,
    parameter int NUM_CH   = 8,
    localparam int SEL_W   = $clog2(NUM_PINS)
) (
    input  logic                      clk_i,
    input  logic                      rst_n_i,
    input  logic [NUM_PINS-1:0]       pins_i,
    input  logic [2*NUM_CH-1:0]       mode_i,
    input  logic [SEL_W*NUM_CH-1:0]   sel_i,
    output logic [NUM_CH-1:0]         fire_o,
    output logic [NUM_CH-1:0]         rise_o
);
    logic [NUM_CH-1:0] lvl;
    logic [NUM_CH-1:0] prev_d, prev_q;

    // source multiplexer: out-of-range selects read as low
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            lvl[c] = 1'b0;
            for (int p = 0; p < NUM_PINS; p++) begin
                if (sel_i[c*SEL_W +: SEL_W] == SEL_W'(p)) lvl[c] = pins_i[p];
            end
        end
        prev_d = lvl;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) prev_q <= '0;
        else          prev_q <= prev_d;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        edge_mode_e mode;
        logic       up, dn;
        assign mode      = edge_mode_e'(mode_i[2*c +: 2]);
        assign up        = lvl[c] & ~prev_q[c];
        assign dn        = ~lvl[c] & prev_q[c];
        assign fire_o[c] = (up && (mode == EDGE_RISE || mode == EDGE_BOTH)) ||
                           (dn && (mode == EDGE_FALL || mode == EDGE_BOTH));
        assign rise_o[c] = up;
    end
endmodule

// File: rtl/evq_fifo.sv
module evq_fifo
    import evq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int DEPTH    = 8,
    parameter int TIME_W   = 32,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                clk_i,
    input  logic                rst_n_i,
    input  logic [NUM_CH-1:0]   fire_i,
    input  logic [NUM_CH-1:0]   rise_i,
    input  logic [TIME_W-1:0]   stamp_i,
    input  logic                pop_i,
    output logic                ready_o,
    output logic [TIME_W-1:0]   head_ts_o,
    output logic [CH_W-1:0]     head_ch_o,
    output logic                head_rise_o,
    output logic [MISS_W-1:0]   head_miss_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] CNT_FULL = (PTR_W+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][TIME_W-1:0] ts;
        logic [DEPTH-1:0][CH_W-1:0]   ch;
        logic [DEPTH-1:0]             rise;
        logic [DEPTH-1:0][MISS_W-1:0] miss;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W:0]               cnt;
        logic [MISS_W-1:0]            lost;
    } fifo_t;

    fifo_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // removal first, so a full queue can take an edge in the same cycle
        if (pop_i && st_d.cnt != '0) begin
            st_d.rd  = st_d.rd + 1'b1;
            st_d.cnt = st_d.cnt - 1'b1;
        end
        // ascending channel order
        for (int c = 0; c < NUM_CH; c++) begin
            if (fire_i[c]) begin
                if (st_d.cnt < CNT_FULL) begin
                    st_d.ts[st_d.wr]   = stamp_i;
                    st_d.ch[st_d.wr]   = CH_W'(c);
                    st_d.rise[st_d.wr] = rise_i[c];
                    st_d.miss[st_d.wr] = st_d.lost;
                    st_d.lost          = '0;
                    st_d.wr            = st_d.wr + 1'b1;
                    st_d.cnt           = st_d.cnt + 1'b1;
                end else begin
                    st_d.lost = miss_inc(st_d.lost);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign ready_o     = (st_q.cnt != '0);
    assign head_ts_o   = st_q.ts[st_q.rd];
    assign head_ch_o   = st_q.ch[st_q.rd];
    assign head_rise_o = st_q.rise[st_q.rd];
    assign head_miss_o = st_q.miss[st_q.rd];
endmodule

// File: rtl/evq_stamp_queue.sv
module evq_stamp_queue
    import evq_pkg::*;
#(
    parameter int NUM_PINS = 12,
    parameter int NUM_CH   = 8,
    parameter int DEPTH    = 8,
    parameter int TIME_W   = 32,
    parameter int LAT_COMP = 35,
    localparam int SEL_W   = $clog2(NUM_PINS),
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                     clk_i,
    input  logic                     rst_n_i,
    input  logic [NUM_PINS-1:0]      pin_i,
    input  logic [TIME_W-1:0]        time_i,
    input  logic [2*NUM_CH-1:0]      ch_mode_i,
    input  logic [SEL_W*NUM_CH-1:0]  ch_sel_i,
    input  logic                     rd_ts_i,
    output logic                     ready_o,
    output logic [CH_W-1:0]          stat_ch_o,
    output logic                     stat_rise_o,
    output logic [MISS_W-1:0]        stat_miss_o,
    output logic [TIME_W-1:0]        ts_o
);
    logic [NUM_PINS-1:0] pins_s;
    logic [NUM_CH-1:0]   fire, rise;
    logic [TIME_W-1:0]   stamp;

    assign stamp = time_i - TIME_W'(LAT_COMP);

    evq_sync #(.N(NUM_PINS), .STAGES(2)) u_sync (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .async_i(pin_i), .sync_o(pins_s)
    );

    evq_edge #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH)) u_edge (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .pins_i(pins_s),
        .mode_i(ch_mode_i), .sel_i(ch_sel_i), .fire_o(fire), .rise_o(rise)
    );

    evq_fifo #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .TIME_W(TIME_W)) u_fifo (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .fire_i(fire), .rise_i(rise),
        .stamp_i(stamp), .pop_i(rd_ts_i), .ready_o(ready_o),
        .head_ts_o(ts_o), .head_ch_o(stat_ch_o), .head_rise_o(stat_rise_o),
        .head_miss_o(stat_miss_o)
    );
endmodule

// File: rtl/evq_checker.sv
module evq_checker #(
    parameter int TIME_W = 32,
    parameter int CH_W   = 3,
    parameter int MISS_W = 2
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              rd_ts_i,
    input logic              ready_o,
    input logic [CH_W-1:0]   stat_ch_o,
    input logic              stat_rise_o,
    input logic [MISS_W-1:0] stat_miss_o,
    input logic [TIME_W-1:0] ts_o
);
    // R10
    reset_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$past(rst_n_i) |-> !ready_o);

    // R5
    ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ready_o && !rd_ts_i |=> ready_o);

    // R6
    head_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ready_o && !rd_ts_i |=> $stable(ts_o) && $stable(stat_ch_o) &&
                                $stable(stat_rise_o) && $stable(stat_miss_o));

    // R5
    ready_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(ready_o) |-> $past(rd_ts_i));
endmodule

bind evq_stamp_queue evq_checker #(.TIME_W(TIME_W), .CH_W(CH_W), .MISS_W(evq_pkg::MISS_W)) u_evq_chk (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .rd_ts_i(rd_ts_i), .ready_o(ready_o),
    .stat_ch_o(stat_ch_o), .stat_rise_o(stat_rise_o), .stat_miss_o(stat_miss_o),
    .ts_o(ts_o)
);

// File: tb/test_evq_stamp_queue.sv
`timescale 1ns/1ps
module test_evq_stamp_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pins = '0;
    logic [31:0] tm = '0;
    logic [15:0] mode = 16'hF939;      // ch7..ch0: both,both,fall,rise,off,both,fall,rise
    logic [31:0] sel  = 32'h9F76_5432; // ch6 selects 15 (out of range)
    logic        rd = 1'b0;
    logic        ready, rise;
    logic [2:0]  ch;
    logic [1:0]  miss;
    logic [31:0] ts;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evq_stamp_queue i_evq_stamp_queue (
        .clk_i(clk), .rst_n_i(rst_n), .pin_i(pins), .time_i(tm),
        .ch_mode_i(mode), .ch_sel_i(sel), .rd_ts_i(rd), .ready_o(ready),
        .stat_ch_o(ch), .stat_rise_o(rise), .stat_miss_o(miss), .ts_o(ts)
    );

    typedef struct packed {
        logic [11:0] pins;
        logic [31:0] t;
        logic        vld;
        logic [2:0]  ch;
        logic        rise;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{12'h004, 32'd20,   1'b1, 3'd0, 1'b1},  // R2 R4 ch0 rise, time wraps
        '{12'h000, 32'd1100, 1'b0, 3'd0, 1'b0},  // R2 rise-only ignores fall
        '{12'h008, 32'd1200, 1'b0, 3'd0, 1'b0},  // R2 fall-only ignores rise
        '{12'h000, 32'd1300, 1'b1, 3'd1, 1'b0},  // R2 ch1 fall
        '{12'h010, 32'd1400, 1'b1, 3'd2, 1'b1},  // R2 both: rise
        '{12'h000, 32'd1500, 1'b1, 3'd2, 1'b0},  // R2 both: fall
        '{12'h020, 32'd1600, 1'b0, 3'd0, 1'b0},  // R2 off channel
        '{12'h021, 32'd1700, 1'b0, 3'd0, 1'b0},  // R3 unselected pin
        '{12'h221, 32'd1800, 1'b1, 3'd7, 1'b1},  // R3 ch7 on pin 9
        '{12'h021, 32'd1900, 1'b1, 3'd7, 1'b0},  // R3 ch7 fall
        '{12'h121, 32'd2000, 1'b0, 3'd0, 1'b0}   // R3 pin 8 only on out-of-range ch6
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop();
        rd = 1'b1; step(1); rd = 1'b0;
    endtask

    task automatic toggle4();
        pins[4] = ~pins[4];
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [31:0] t1;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk(ready == 1'b0, "R10 empty after reset", 32'(ready), 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            pins = VEC[v].pins;
            tm   = VEC[v].t;
            step(2);
            chk(ready == 1'b0, "R1 not yet stored after P2", 32'(ready), 0);
            step(1);
            chk(ready == VEC[v].vld, "R1/R2/R3 ready", 32'(ready), 32'(VEC[v].vld));
            if (VEC[v].vld) begin
                chk(ch == VEC[v].ch, "R3 channel", 32'(ch), 32'(VEC[v].ch));
                chk(rise == VEC[v].rise, "R2 direction", 32'(rise), 32'(VEC[v].rise));
                chk(miss == 2'd0, "R8 no loss", 32'(miss), 0);
                chk(ts == VEC[v].t - 32'd35, "R4 compensated time", ts, VEC[v].t - 32'd35);
                pop();
                chk(ready == 1'b0, "R6 pop empties", 32'(ready), 0);
            end
        end

        // R7 simultaneous channels
        tm = 32'd5000;
        pins = 12'h235;
        step(3);
        for (int k = 0; k < 3; k++) begin
            logic [2:0] e;
            e = (k == 0) ? 3'd0 : (k == 1) ? 3'd2 : 3'd7;
            chk(ready == 1'b1, "R7 ready", 32'(ready), 1);
            chk(ch == e, "R7 ascending order", 32'(ch), 32'(e));
            chk(ts == 32'd4965, "R7 shared time", ts, 32'd4965);
            pop();
        end
        chk(ready == 1'b0, "R7 three records only", 32'(ready), 0);

        // R8 overflow with saturation
        tm = 32'd6000;
        for (int k = 0; k < 13; k++) begin toggle4(); step(1); end
        step(3);
        chk(miss == 2'd0, "R8 first record no loss", 32'(miss), 0);
        pop();
        tm = 32'd7000;
        toggle4(); step(3);
        for (int k = 0; k < 7; k++) begin
            chk(miss == 2'd0, "R8 older records no loss", 32'(miss), 0);
            chk(ts == 32'd5965, "R8 older time", ts, 32'd5965);
            pop();
        end
        chk(ready == 1'b1, "R8 new record kept", 32'(ready), 1);
        chk(miss == 2'd3, "R8 saturated loss count", 32'(miss), 3);
        chk(ts == 32'd6965, "R8 new record time", ts, 32'd6965);
        pop();
        chk(ready == 1'b0, "R8 depth 8", 32'(ready), 0);
        toggle4(); step(3);
        chk(miss == 2'd0, "R8 loss count cleared", 32'(miss), 0);
        pop();

        // R9 pop and capture in the same cycle on a full queue
        tm = 32'd8000;
        for (int k = 0; k < 8; k++) begin toggle4(); step(1); end
        step(3);
        t1 = 32'd9000;
        tm = t1;
        toggle4();
        step(2);
        rd = 1'b1; step(1); rd = 1'b0;
        cnt = 0;
        while (ready && cnt < 12) begin
            chk(miss == 2'd0, "R9 nothing lost", 32'(miss), 0);
            if (cnt == 7) chk(ts == t1 - 32'd35, "R9 new record last", ts, t1 - 32'd35);
            pop();
            cnt++;
        end
        chk(cnt == 8, "R9 record count", 32'(cnt), 8);

        // R6 pop while empty is ignored
        tm = 32'd10000;
        pop(); pop();
        chk(ready == 1'b0, "R6 empty pop", 32'(ready), 0);
        toggle4(); step(3);
        chk(ready == 1'b1, "R6 queue intact after empty pop", 32'(ready), 1);
        chk(ts == 32'd9965, "R6 head after empty pop", ts, 32'd9965);
        pop();
        chk(ready == 1'b0, "R6 single record", 32'(ready), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule